// File: doc/BRIEF.md
# Per-Core Private Interrupt Collector

This block sits between one processor core and its CPU interface. It takes the six interrupt lines that belong to that core alone and turns them into requests the core can act on. Two of the lines are legacy request pins that are active low: one for fast interrupts and one for normal interrupts. The other four are active-high level outputs from the core's timers: secure physical, non-secure physical, virtual and hypervisor.

The block has two modes. After reset it is in bypass, and the two legacy pins drive the core's FIQ and IRQ requests directly. When the CPU interface is enabled, all six lines become level-sensitive pending bits with fixed interrupt IDs from 26 to 31. Each source can be masked on its own. A fixed priority reports the lowest pending ID as the acknowledge ID. When nothing is pending, the acknowledge ID is the spurious value 1023.

Every output is registered. Each output shows the inputs sampled at the previous rising clock edge.

Top module: `pic_private_collector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `core_fiq_o` and `core_irq_o` are 0, `pend_o` is 0 and `ack_id_o` is 1023.
- R2: When `cpuif_en_i` was 0 at the previous edge (bypass), `core_fiq_o` equals the inverse of `legacy_fiq_n_i` and `core_irq_o` equals the inverse of `legacy_irq_n_i`, as sampled at that edge.
- R3: In bypass, the timer inputs and `src_en_i` have no effect: `pend_o` is 0 and `ack_id_o` is 1023.
- R4: `cpuif_en_i` switches the mode. The outputs follow the new mode one cycle after a change is sampled, in either direction.
- R5: When the CPU interface is enabled, the legacy pins are active low. `pend_o[2]` (ID 28) is set while `legacy_fiq_n_i` is 0, and `pend_o[5]` (ID 31) is set while `legacy_irq_n_i` is 0.
- R6: When the CPU interface is enabled, bit k of `pend_o` stands for ID 26+k. The hypervisor timer maps to bit 0 (ID 26), the virtual timer to bit 1 (ID 27), the secure physical timer to bit 3 (ID 29) and the non-secure physical timer to bit 4 (ID 30).
- R7: Pending bits follow the input level. A bit clears one cycle after its source goes inactive, whether or not it was acknowledged.
- R8: `src_en_i` uses the same bit order as `pend_o`. A source whose enable bit is 0 never shows as pending.
- R9: When one or more bits are pending, `ack_id_o` is 26 plus the index of the lowest set bit of `pend_o`, so the lowest ID wins.
- R10: When the CPU interface is enabled and no bit is pending, `ack_id_o` is 1023.
- R11: When the CPU interface is enabled, `core_irq_o` is 1 exactly when some bit is pending, and `core_fiq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpuif_en_i | input | 1 | 1 = CPU interface enabled, 0 = bypass |
| src_en_i | input | 6 | Per-source enable, bit k for ID 26+k |
| legacy_fiq_n_i | input | 1 | Legacy fast request pin, active low |
| legacy_irq_n_i | input | 1 | Legacy normal request pin, active low |
| tmr_sec_phys_i | input | 1 | Secure physical timer level |
| tmr_ns_phys_i | input | 1 | Non-secure physical timer level |
| tmr_virt_i | input | 1 | Virtual timer level |
| tmr_hyp_i | input | 1 | Hypervisor timer level |
| core_fiq_o | output | 1 | FIQ request to the core |
| core_irq_o | output | 1 | IRQ request to the core |
| pend_o | output | 6 | Pending bits, bit k for ID 26+k |
| ack_id_o | output | 10 | Highest-priority pending ID, or 1023 |

## Verification
The hardest case to reach is a mode change made while sources are asserted. The bench has to show two things there. Timer levels held through bypass must never leak into `pend_o`. The legacy pins must move from the request outputs into pending bits 2 and 5 exactly one cycle after `cpuif_en_i` is sampled. The directed phases hold timers and pins asserted across both directions of the switch. Randomised traffic then toggles `cpuif_en_i` together with random enable masks and levels. A behavioural model indexed by ID number predicts every output on every cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned PIC_NUM_SRC  = 6;
    localparam int unsigned PIC_ID_W     = 10;
    localparam int unsigned PIC_BASE_ID  = 26;
    localparam int unsigned PIC_SPUR_ID  = (1 << PIC_ID_W) - 1;

    // Bit index within the source vector: bit k carries ID PIC_BASE_ID + k
    localparam int unsigned IDX_HYP  = 0;
    localparam int unsigned IDX_VIRT = 1;
    localparam int unsigned IDX_LFIQ = 2;
    localparam int unsigned IDX_SPHY = 3;
    localparam int unsigned IDX_NPHY = 4;
    localparam int unsigned IDX_LIRQ = 5;

    // Lines whose raw input is active low
    localparam logic [PIC_NUM_SRC-1:0] PIC_ACT_LOW =
        (PIC_NUM_SRC)'((1 << IDX_LFIQ) | (1 << IDX_LIRQ));

    typedef logic [PIC_NUM_SRC-1:0] src_vec_t;
    typedef logic [PIC_ID_W-1:0]    irq_id_t;

    typedef struct packed {
        logic     fiq;
        logic     irq;
        src_vec_t pend;
        irq_id_t  id;
    } pic_state_t;

endpackage

// File: rtl/pic_src_cond.sv
module pic_src_cond #(
    parameter int unsigned          NUM_SRC = 6,
    parameter logic [NUM_SRC-1:0]   ACT_LOW = '0
) (
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               gate_i,
    output logic [NUM_SRC-1:0] level_o,
    output logic [NUM_SRC-1:0] req_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
        if (ACT_LOW[g]) begin : g_low
            assign level_o[g] = ~raw_i[g];
        end else begin : g_high
            assign level_o[g] = raw_i[g];
        end
        assign req_o[g] = level_o[g] & en_i[g] & gate_i;
    end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int unsigned N       = 6,
    parameter int unsigned ID_W    = 10,
    parameter int unsigned BASE_ID = 26,
    parameter int unsigned NONE_ID = 1023
) (
    input  logic [N-1:0]    req_i,
    output logic            any_o,
    output logic [ID_W-1:0] id_o
);
    always_comb begin
        any_o = 1'b0;
        id_o  = ID_W'(NONE_ID);
        // Scan downward so the lowest set index is assigned last and wins
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                id_o  = ID_W'(BASE_ID + i);
            end
        end
    end
endmodule

// File: rtl/pic_private_collector.sv
module pic_private_collector
    import pic_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   cpuif_en_i,
    input  logic [PIC_NUM_SRC-1:0] src_en_i,
    input  logic                   legacy_fiq_n_i,
    input  logic                   legacy_irq_n_i,
    input  logic                   tmr_sec_phys_i,
    input  logic                   tmr_ns_phys_i,
    input  logic                   tmr_virt_i,
    input  logic                   tmr_hyp_i,
    output logic                   core_fiq_o,
    output logic                   core_irq_o,
    output logic [PIC_NUM_SRC-1:0] pend_o,
    output logic [PIC_ID_W-1:0]    ack_id_o
);
    localparam pic_state_t RST_STATE = '{
        fiq:  1'b0,
        irq:  1'b0,
        pend: '0,
        id:   PIC_ID_W'(PIC_SPUR_ID)
    };

    src_vec_t   raw_vec;
    src_vec_t   level_vec;
    src_vec_t   req_vec;
    logic       req_any;
    irq_id_t    req_id;
    pic_state_t st_d, st_q;

    always_comb begin
        raw_vec           = '0;
        raw_vec[IDX_HYP]  = tmr_hyp_i;
        raw_vec[IDX_VIRT] = tmr_virt_i;
        raw_vec[IDX_LFIQ] = legacy_fiq_n_i;
        raw_vec[IDX_SPHY] = tmr_sec_phys_i;
        raw_vec[IDX_NPHY] = tmr_ns_phys_i;
        raw_vec[IDX_LIRQ] = legacy_irq_n_i;
    end

    pic_src_cond #(
        .NUM_SRC (PIC_NUM_SRC),
        .ACT_LOW (PIC_ACT_LOW)
    ) src_cond_i (
        .raw_i   (raw_vec),
        .en_i    (src_en_i),
        .gate_i  (cpuif_en_i),
        .level_o (level_vec),
        .req_o   (req_vec)
    );

    pic_prio_enc #(
        .N       (PIC_NUM_SRC),
        .ID_W    (PIC_ID_W),
        .BASE_ID (PIC_BASE_ID),
        .NONE_ID (PIC_SPUR_ID)
    ) prio_enc_i (
        .req_i (req_vec),
        .any_o (req_any),
        .id_o  (req_id)
    );

    always_comb begin
        st_d = st_q;
        if (!cpuif_en_i) begin
            // Bypass: legacy pins go straight to the core
            st_d.fiq  = level_vec[IDX_LFIQ];
            st_d.irq  = level_vec[IDX_LIRQ];
            st_d.pend = '0;
            st_d.id   = PIC_ID_W'(PIC_SPUR_ID);
        end else begin
            st_d.fiq  = 1'b0;
            st_d.irq  = req_any;
            st_d.pend = req_vec;
            st_d.id   = req_id;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_fiq_o = st_q.fiq;
    assign core_irq_o = st_q.irq;
    assign pend_o     = st_q.pend;
    assign ack_id_o   = st_q.id;

    // R2
    bypass_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpuif_en_i |=> (core_fiq_o == !$past(legacy_fiq_n_i)) &&
                        (core_irq_o == !$past(legacy_irq_n_i)));

    // R3
    bypass_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpuif_en_i |=> (pend_o == '0) && (ack_id_o == PIC_ID_W'(PIC_SPUR_ID)));

    // R8
    mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pend_o & ~$past(src_en_i)) == '0));

    // R9
    id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o != '0) |-> (ack_id_o >= PIC_ID_W'(PIC_BASE_ID)) &&
                           (ack_id_o < PIC_ID_W'(PIC_BASE_ID + PIC_NUM_SRC)));

    // R10
    spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o == '0) |-> (ack_id_o == PIC_ID_W'(PIC_SPUR_ID)));

    // R11
    cpuif_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpuif_en_i |=> !core_fiq_o && (core_irq_o == (pend_o != '0)));

endmodule

// File: tb/pic_private_collector_tb.sv
`timescale 1ns/1ps
module pic_private_collector_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpuif = 1'b0;
    logic [5:0] en = '0;
    logic       nfiq = 1'b1, nirq = 1'b1;
    logic       sphy = 1'b0, nphy = 1'b0, virt = 1'b0, hyp = 1'b0;
    logic       fiq_o, irq_o;
    logic [5:0] pend_o;
    logic [9:0] id_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;
    string cur_tag = "";

    // Reference model outputs
    logic       e_fiq = 0, e_irq = 0, e_byp = 1;
    logic [5:0] e_pend = 0;
    int         e_id = 1023;

    always #2 clk = ~clk;

    pic_private_collector dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cpuif_en_i(cpuif), .src_en_i(en),
        .legacy_fiq_n_i(nfiq), .legacy_irq_n_i(nirq),
        .tmr_sec_phys_i(sphy), .tmr_ns_phys_i(nphy),
        .tmr_virt_i(virt), .tmr_hyp_i(hyp),
        .core_fiq_o(fiq_o), .core_irq_o(irq_o), .pend_o(pend_o), .ack_id_o(id_o)
    );

    function automatic bit src_active(int id);
        case (id)
            26: return hyp;
            27: return virt;
            28: return !nfiq;
            29: return sphy;
            30: return nphy;
            31: return !nirq;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_fiq <= 0; e_irq <= 0; e_pend <= 0; e_id <= 1023; e_byp <= 1;
        end else if (!cpuif) begin
            e_fiq <= !nfiq; e_irq <= !nirq; e_pend <= 0; e_id <= 1023; e_byp <= 1;
        end else begin
            logic [5:0] p;
            int best;
            p = 0; best = 1023;
            for (int id = 31; id >= 26; id--) begin
                if (src_active(id) && en[id-26]) begin
                    p[id-26] = 1'b1;
                    best = id;
                end
            end
            e_fiq <= 0; e_irq <= (p != 0); e_pend <= p; e_id <= best; e_byp <= 0;
        end
    end

    task automatic cmp(string tag, int act, int exp, string what);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string tf, tp, ti;
        tf = (cur_tag != "") ? cur_tag : (e_byp ? "R2" : "R11");
        tp = (cur_tag != "") ? cur_tag : (e_byp ? "R3" : "R6");
        ti = (cur_tag != "") ? cur_tag : (e_byp ? "R3" : ((e_pend == 0) ? "R10" : "R9"));
        cmp(tf, int'(fiq_o), int'(e_fiq), "core_fiq_o");
        cmp(tf, int'(irq_o), int'(e_irq), "core_irq_o");
        cmp(tp, int'(pend_o), int'(e_pend), "pend_o");
        cmp(ti, int'(id_o), e_id, "ack_id_o");
    endtask

    // Check the result of the previous step, then drive the next inputs
    task automatic step(string tag, logic c, logic [5:0] e, logic nf, logic ni,
                        logic s, logic n, logic v, logic h);
        @(negedge clk);
        check_all();
        cpuif = c; en = e; nfiq = nf; nirq = ni;
        sphy = s; nphy = n; virt = v; hyp = h;
        cur_tag = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        cmp("R1", int'(fiq_o), 0, "core_fiq_o");
        cmp("R1", int'(irq_o), 0, "core_irq_o");
        cmp("R1", int'(pend_o), 0, "pend_o");
        cmp("R1", int'(id_o), 1023, "ack_id_o");
        rst_n = 1'b1;
        cur_tag = "R1";

        // R2 / R3: bypass, timers asserted and enabled but must not appear
        step("R2", 0, 6'h3F, 0, 1, 1, 1, 1, 1);
        step("R2", 0, 6'h3F, 1, 0, 1, 1, 1, 1);
        step("R3", 0, 6'h3F, 0, 0, 1, 0, 1, 0);
        step("R3", 0, 6'h00, 1, 1, 1, 1, 1, 1);
        // R4: enable the interface while everything is held asserted
        step("R4", 1, 6'h3F, 1, 1, 1, 1, 1, 1);
        // R6: one timer at a time
        step("R6", 1, 6'h3F, 1, 1, 0, 0, 0, 1);
        step("R6", 1, 6'h3F, 1, 1, 0, 0, 1, 0);
        step("R6", 1, 6'h3F, 1, 1, 1, 0, 0, 0);
        step("R6", 1, 6'h3F, 1, 1, 0, 1, 0, 0);
        // R5: legacy pins active low as pending bits
        step("R5", 1, 6'h3F, 0, 1, 0, 0, 0, 0);
        step("R5", 1, 6'h3F, 1, 0, 0, 0, 0, 0);
        step("R5", 1, 6'h3F, 1, 1, 0, 0, 0, 0);
        // R7: level drops without acknowledge
        step("R7", 1, 6'h3F, 1, 1, 1, 1, 0, 0);
        step("R7", 1, 6'h3F, 1, 1, 0, 1, 0, 0);
        step("R7", 1, 6'h3F, 1, 1, 0, 0, 0, 0);
        // R9: lowest ID wins
        step("R9", 1, 6'h3F, 0, 0, 0, 1, 0, 0);
        step("R9", 1, 6'h3F, 0, 0, 0, 1, 1, 0);
        step("R9", 1, 6'h3F, 0, 0, 1, 1, 1, 1);
        // R8: masking hides sources, lowest enabled wins
        step("R8", 1, 6'h30, 0, 0, 1, 1, 1, 1);
        step("R8", 1, 6'h0C, 1, 1, 0, 0, 1, 1);
        step("R8", 1, 6'h00, 0, 0, 1, 1, 1, 1);
        // R10: nothing pending
        step("R10", 1, 6'h3F, 1, 1, 0, 0, 0, 0);
        // R11: request aggregation
        step("R11", 1, 6'h3F, 0, 1, 0, 0, 0, 0);
        // R4: return to bypass while timers are held
        step("R4", 0, 6'h3F, 0, 1, 1, 1, 1, 1);
        step("R4", 0, 6'h3F, 1, 1, 1, 1, 1, 1);

        // Randomised traffic with mode toggles
        for (int k = 0; k < 3000; k++) begin
            logic [9:0] r;
            r = 10'($urandom);
            step("", ($urandom_range(0, 7) != 0), 6'($urandom),
                 ($urandom_range(0, 2) != 0), ($urandom_range(0, 2) != 0),
                 r[0], r[1], r[2], r[3]);
        end
        step("", 0, 0, 1, 1, 0, 0, 0, 0);
        step("", 0, 0, 1, 1, 0, 0, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule